// File: doc/BRIEF.md
# Split-Row Min-Sum Check Node

This block performs the check-node (row) update for one half of a split parity-check row in a min-sum LDPC decoder. It accepts one signed soft message per column in its half of the row. For each of those columns it returns one signed, scaled message. The magnitude returned to a column is the smallest magnitude among the other columns in the same half. That value is scaled by a factor below one. The scaling offsets the larger magnitudes that appear when a row is split in two.

Only one bit passes between the two halves of a row. Each half sends the parity of its own input signs to its partner and receives the partner's parity back. The output sign for a column combines the signs of the other local columns with that received bit. Two such blocks, with their sign ports cross-connected, form one complete split row.

The core is combinational, and an optional output register is placed after it. A valid strobe travels alongside the data.

Top module: `split_row_check_node`

## Requirements
- R1: `peerSignOut` is, in the same cycle and combinationally, the XOR of the sign bits of all lane inputs. Lane j of `inMsg` occupies bits [5j+4:5j]: bit 5j+4 is the sign (1 = negative) and bits [5j+3:5j] are an unsigned magnitude.
- R2: Before scaling, the output magnitude of lane j equals the smallest input magnitude among all other lanes, with lane j left out.
- R3: When two or more lanes share the smallest magnitude, every lane gets that smallest value before scaling, including the lanes that hold it.
- R4: The output sign of lane j is the XOR of the signs of all other lanes and `peerSignIn`.
- R5: With the default scale select (1), the pre-scale magnitude m is output as (m>>2)+(m>>3), truncated. Select 0 gives m>>1 and select 2 gives m unchanged. The output uses the same lane layout as the input.
- R6: With the default output register enabled, `outMsg` presents the result for a valid input one clock after the edge that samples `inValid` high. `outValid` is high in exactly that cycle.
- R7: While reset is held and after it is released, until the first valid input, `outValid` is 0 and `outMsg` is all zeros.
- R8: An input presented with `inValid` low has no effect: `outMsg` keeps the last result and `outValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Marks inMsg and peerSignIn as a valid set |
| inMsg | input | HALF_W*5 | Lane messages, sign-magnitude, lane j at [5j+4:5j] |
| peerSignIn | input | 1 | Sign parity received from the partner half |
| peerSignOut | output | 1 | Sign parity of local inputs sent to the partner half |
| outValid | output | 1 | Marks outMsg as a new result |
| outMsg | output | HALF_W*5 | Scaled messages returned to the lanes |

## Verification
`peerSignOut` is combinational, so it is checked one time step after the inputs are driven, within the same cycle. Every valid input set puts one expected result into a queue. The monitor samples just after each rising edge and pops an entry only when `outValid` is high. A result that arrives one edge early or late therefore fails against the queue contents, or leaves the queue non-empty at the end of the run. Idle cycles with changing inputs are checked at the same sampling point to confirm that the held output does not change.

// File: rtl/srcn_pkg.sv
package srcn_pkg;
  typedef struct packed {
    logic load;
  } srcn_strobe_t;
endpackage

// File: rtl/srcn_minsearch.sv
module srcn_minsearch #(
  parameter int HALF_W = 3,
  parameter int MAG_W  = 4,
  localparam int IDX_W = (HALF_W > 1) ? $clog2(HALF_W) : 1
) (
  input  logic [HALF_W*MAG_W-1:0] magVec,
  output logic [MAG_W-1:0]        min1,
  output logic [MAG_W-1:0]        min2,
  output logic [IDX_W-1:0]        minIdx
);
  always_comb begin
    logic [MAG_W-1:0] m;
    min1   = '1;
    min2   = '1;
    minIdx = '0;
    for (int i = 0; i < HALF_W; i++) begin
      m = magVec[i*MAG_W +: MAG_W];
      if (m < min1) begin
        min2   = min1;
        min1   = m;
        minIdx = IDX_W'(i);
      end else if (m < min2) begin
        min2 = m;
      end
    end
  end
endmodule

// File: rtl/srcn_ctrl.sv
module srcn_ctrl import srcn_pkg::*; #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output srcn_strobe_t strobe,
  output logic         outValid
);
  assign strobe.load = inValid;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outValid <= 1'b0;
        else       outValid <= inValid;
      end
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/srcn_datapath.sv
module srcn_datapath import srcn_pkg::*; #(
  parameter int HALF_W    = 3,
  parameter int MAG_W     = 4,
  parameter int SCALE_SEL = 1,
  parameter bit OUT_REG   = 1'b1,
  localparam int MSG_W = MAG_W + 1,
  localparam int IDX_W = (HALF_W > 1) ? $clog2(HALF_W) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  srcn_strobe_t            strobe,
  input  logic [HALF_W*MSG_W-1:0] inMsg,
  input  logic                    peerSignIn,
  output logic                    peerSignOut,
  output logic [HALF_W*MSG_W-1:0] outMsg
);
  logic [HALF_W*MAG_W-1:0] magVec;
  logic [HALF_W-1:0]       signVec;
  logic [MAG_W-1:0]        min1, min2;
  logic [IDX_W-1:0]        minIdx;
  logic                    localParity;
  logic [HALF_W*MSG_W-1:0] nextMsg;

  generate
    for (genvar g = 0; g < HALF_W; g++) begin : g_unpack
      assign magVec[g*MAG_W +: MAG_W] = inMsg[g*MSG_W +: MAG_W];
      assign signVec[g]               = inMsg[g*MSG_W + MAG_W];
    end
  endgenerate

  assign localParity = ^signVec;
  assign peerSignOut = localParity;

  srcn_minsearch #(.HALF_W(HALF_W), .MAG_W(MAG_W)) uMin (
    .magVec(magVec), .min1(min1), .min2(min2), .minIdx(minIdx)
  );

  generate
    for (genvar g = 0; g < HALF_W; g++) begin : g_lane
      logic [MAG_W-1:0] rawMag;
      logic [MAG_W-1:0] scaledMag;
      logic             laneSign;
      assign rawMag   = (minIdx == IDX_W'(g)) ? min2 : min1;
      assign laneSign = localParity ^ signVec[g] ^ peerSignIn;
      if (SCALE_SEL == 0) begin : g_half
        assign scaledMag = rawMag >> 1;
      end else if (SCALE_SEL == 1) begin : g_3_8
        assign scaledMag = (rawMag >> 2) + (rawMag >> 3);
      end else begin : g_unity
        assign scaledMag = rawMag;
      end
      assign nextMsg[g*MSG_W +: MSG_W] = {laneSign, scaledMag};
    end
  endgenerate

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            outMsg <= '0;
        else if (strobe.load) outMsg <= nextMsg;
      end
    end else begin : g_ocomb
      assign outMsg = nextMsg;
    end
  endgenerate
endmodule

// File: rtl/split_row_check_node.sv
module split_row_check_node import srcn_pkg::*; #(
  parameter int HALF_W    = 3,
  parameter int MAG_W     = 4,
  parameter int SCALE_SEL = 1,
  parameter bit OUT_REG   = 1'b1,
  localparam int MSG_W = MAG_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [HALF_W*MSG_W-1:0] inMsg,
  input  logic                    peerSignIn,
  output logic                    peerSignOut,
  output logic                    outValid,
  output logic [HALF_W*MSG_W-1:0] outMsg
);
  srcn_strobe_t strobe;

  srcn_ctrl #(.OUT_REG(OUT_REG)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  srcn_datapath #(
    .HALF_W(HALF_W), .MAG_W(MAG_W), .SCALE_SEL(SCALE_SEL), .OUT_REG(OUT_REG)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inMsg(inMsg), .peerSignIn(peerSignIn),
    .peerSignOut(peerSignOut), .outMsg(outMsg)
  );
endmodule

// File: rtl/srcn_checker.sv
module srcn_checker #(
  parameter int HALF_W    = 3,
  parameter int MAG_W     = 4,
  parameter int SCALE_SEL = 1,
  parameter bit OUT_REG   = 1'b1,
  localparam int MSG_W = MAG_W + 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [HALF_W*MSG_W-1:0] inMsg,
  input logic                    peerSignOut,
  input logic                    outValid,
  input logic [HALF_W*MSG_W-1:0] outMsg
);
  localparam int MAG_MAX = (1 << MAG_W) - 1;
  localparam int OUT_MAX = (SCALE_SEL == 0) ? (MAG_MAX >> 1) :
                           (SCALE_SEL == 1) ? ((MAG_MAX >> 2) + (MAG_MAX >> 3)) : MAG_MAX;

  logic [HALF_W-1:0] inSigns;
  generate
    for (genvar g = 0; g < HALF_W; g++) begin : g_s
      assign inSigns[g] = inMsg[g*MSG_W + MAG_W];
    end
  endgenerate

  // R1: exported sign equals parity of local signs
  p_peer_parity_r1: assert property (@(posedge clk) disable iff (!rstN)
    peerSignOut == $countones(inSigns) % 2);

  generate
    if (OUT_REG) begin : g_seq
      p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(outMsg));
    end
    for (genvar g = 0; g < HALF_W; g++) begin : g_bound
      p_scaled_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> int'(outMsg[g*MSG_W +: MAG_W]) <= OUT_MAX);
    end
  endgenerate
endmodule

bind split_row_check_node srcn_checker #(
  .HALF_W(HALF_W), .MAG_W(MAG_W), .SCALE_SEL(SCALE_SEL), .OUT_REG(OUT_REG)
) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inMsg(inMsg),
  .peerSignOut(peerSignOut), .outValid(outValid), .outMsg(outMsg)
);

// File: tb/tb_split_row_check_node.sv
module tb_split_row_check_node;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W = 3;
  localparam int MAG_W  = 4;
  localparam int MSG_W  = MAG_W + 1;
  localparam int VW     = HALF_W * MSG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [VW-1:0] inMsg = '0;
  logic peerSignIn = 1'b0;
  logic peerSignOut, outValid;
  logic [VW-1:0] outMsg;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct { logic [VW-1:0] exp; string tag; } item_t;
  item_t q[$];
  logic [VW-1:0] lastExp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_row_check_node dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMsg(inMsg), .peerSignIn(peerSignIn),
    .peerSignOut(peerSignOut), .outValid(outValid), .outMsg(outMsg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] model(input logic [VW-1:0] m, input logic p);
    logic [VW-1:0] r;
    r = '0;
    for (int j = 0; j < HALF_W; j++) begin
      int mn;
      logic s;
      mn = 1000;
      s = p;
      for (int k = 0; k < HALF_W; k++) begin
        if (k != j) begin
          if (int'(m[k*MSG_W +: MAG_W]) < mn) mn = int'(m[k*MSG_W +: MAG_W]);
          s ^= m[k*MSG_W + MAG_W];
        end
      end
      r[j*MSG_W + MAG_W] = s;
      r[j*MSG_W +: MAG_W] = MAG_W'((mn >> 2) + (mn >> 3));
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] pack3(input int m0, m1, m2, input bit s0, s1, s2);
    return {s2, 4'(m2), s1, 4'(m1), s0, 4'(m0)};
  endfunction

  task automatic drive(input logic [VW-1:0] m, input logic p, input string tag);
    item_t it;
    @(negedge clk);
    inMsg = m;
    peerSignIn = p;
    inValid = 1'b1;
    it.exp = model(m, p);
    it.tag = tag;
    q.push_back(it);
    lastExp = it.exp;
    #1;
    check(peerSignOut == (m[4] ^ m[9] ^ m[14]), "R1", int'(peerSignOut), int'(m[4] ^ m[9] ^ m[14]));
  endtask

  task automatic idle(input logic [VW-1:0] junk);
    @(negedge clk);
    inValid = 1'b0;
    inMsg = junk;
    peerSignIn = ~peerSignIn;
    @(posedge clk);
    #1;
    check(outValid == 1'b0, "R8 valid", int'(outValid), 0);
    check(outMsg == lastExp, "R8 hold", int'(outMsg), int'(lastExp));
  endtask

  // monitor: pops expected results as outValid appears
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && outValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R6 unexpected result", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          for (int j = 0; j < HALF_W; j++) begin
            check(outMsg[j*MSG_W +: MAG_W] == it.exp[j*MSG_W +: MAG_W],
                  $sformatf("%s magnitude lane %0d", it.tag, j),
                  int'(outMsg[j*MSG_W +: MAG_W]), int'(it.exp[j*MSG_W +: MAG_W]));
            check(outMsg[j*MSG_W + MAG_W] == it.exp[j*MSG_W + MAG_W],
                  $sformatf("R4 sign lane %0d", j),
                  int'(outMsg[j*MSG_W + MAG_W]), int'(it.exp[j*MSG_W + MAG_W]));
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R7 valid in reset", int'(outValid), 0);
    check(outMsg == '0, "R7 data in reset", int'(outMsg), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R7 valid after reset", int'(outValid), 0);
    check(outMsg == '0, "R7 data after reset", int'(outMsg), 0);

    drive(pack3(5, 9, 2, 0, 0, 0), 1'b0, "R2");
    idle(pack3(1, 1, 1, 1, 0, 1));
    drive(pack3(15, 15, 15, 1, 0, 0), 1'b1, "R5 max");
    drive(pack3(12, 9, 14, 1, 1, 0), 1'b0, "R5");
    drive(pack3(4, 4, 12, 0, 1, 1), 1'b1, "R3 tie");
    drive(pack3(8, 13, 8, 1, 1, 1), 1'b0, "R3 tie split");
    drive(pack3(7, 7, 7, 0, 0, 1), 1'b1, "R3 all equal");
    idle(pack3(0, 0, 0, 1, 1, 1));
    idle(pack3(15, 3, 9, 0, 1, 0));
    drive(pack3(0, 11, 15, 1, 0, 1), 1'b0, "R2 zero");
    drive(pack3(15, 8, 11, 0, 0, 0), 1'b1, "R5");
    for (int n = 0; n < 40; n++) begin
      drive(VW'($urandom), 1'($urandom), "R2 random");
      if (n % 7 == 3) idle(VW'($urandom));
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(q.size() == 0, "R6 all results delivered", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule